// File: doc/BRIEF.md
# Lane-Split Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit operands as a packed vector of signed two's-complement lanes. The lane width is chosen on every operation: one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. The carry chain is broken at the lane edges that the chosen width implies, so each lane computes on its own. Subtraction feeds the inverted second operand into the same adders and injects a carry of one at the bottom of every lane.

Every lane detects signed overflow from the operand and result signs. When saturation is enabled, an overflowing lane is clamped to the signed limit on the side of the true result. When saturation is off, the lane keeps the wrapped low bits, and the overflow flag is still raised. One overflow bit is reported per byte position, so a wide lane drives all of its bytes' flag bits together.

Result and flags are captured in a register when an operation is strobed in. They appear on the next clock with a one-cycle valid pulse, and they hold until the next strobe.

Top module: `simd_sat_addsub`

## Requirements
- R1: `lane_mode` sets the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 four 16-bit lanes, 2'b10 two 32-bit lanes, 2'b11 one 64-bit lane. Lane k of width W occupies bits k*W+W-1 down to k*W.
- R2: No carry or borrow passes from one lane into the next. For example, in 8-bit mode, all-ones plus 0x0101..01 gives zero in every byte.
- R3: With `op_sub`=0, each lane's result is the lane sum of `opa` and `opb`, taken modulo 2^W when it does not saturate.
- R4: With `op_sub`=1, each lane's result is `opa` plus the two's-complement negation of `opb`, modulo 2^W when it does not saturate.
- R5: Addition overflows only when both lane operands have the same sign and the result sign differs. Operands of opposite sign never overflow.
- R6: Subtraction overflows only when the lane operands differ in sign and the result sign differs from the `opa` sign. Operands of equal sign never overflow.
- R7: With `sat_en`=1, a lane that overflows upward outputs 0x7F followed by all-ones bytes, that is 2^(W-1)-1.
- R8: With `sat_en`=1, a lane that overflows downward outputs 0x80 followed by all-zero bytes, that is -2^(W-1).
- R9: With `sat_en`=0, an overflowing lane outputs the wrapped low W bits, and its overflow flag is still set.
- R10: `ovf_flags` bit i is the overflow of the lane that contains byte i (bits 8i+7:8i), so all bytes of one lane carry the same flag.
- R11: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high, and it is low otherwise.
- R12: `result` and `ovf_flags` keep their values while `in_valid` is low.
- R13: A synchronous reset clears `out_valid`, `result` and `ovf_flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures an operation |
| lane_mode | input | 2 | Lane width select |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| sat_en | input | 1 | 1 = saturate on overflow, 0 = wrap |
| opa | input | 64 | First operand vector |
| opb | input | 64 | Second operand vector |
| out_valid | output | 1 | One-cycle pulse for a new result |
| result | output | 64 | Registered lane results |
| ovf_flags | output | 8 | Registered overflow flag per byte position |

## Verification
The bench sweeps every 8-bit value of the second operand against a strided sweep of the first, with a different value in each byte. It does this for all four add/subtract and wrap/saturate combinations, so a carry leaking between bytes or an off-by-one clamp shows up in some lane. For the wider lanes it combines the signed extremes (zero, ±1, maximum, minimum and their neighbours) with pseudo-random vectors. This catches a clamp that takes its direction from the result sign instead of the operand sign. It also catches a subtraction that drops its injected carry above byte 0, and flags that come from the wrong byte of a wide lane. A final all-ones-plus-one pattern exposes a lane cut placed at the wrong width, and strobe-gap checks expose an output register that loads without a strobe.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W     = 64;
    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = DATA_W / BYTE_W;
    localparam int BYTE_IDX_W = $clog2(NUM_BYTES);

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]    data;
        logic [NUM_BYTES-1:0] ovf;
    } lane_pkt_t;

    // Bytes per lane minus one: the low-index mask within a lane.
    function automatic logic [BYTE_IDX_W-1:0] lane_span(lane_mode_e m);
        logic [BYTE_IDX_W:0] bytes;
        bytes = (BYTE_IDX_W+1)'(1) << m;
        return BYTE_IDX_W'(bytes - 1'b1);
    endfunction

endpackage

// File: rtl/simd_lane_cut.sv
module simd_lane_cut
    import simd_pkg::*;
(
    input  lane_mode_e                             mode,
    output logic [NUM_BYTES-1:0]                   cut,
    output logic [NUM_BYTES-1:0]                   is_top,
    output logic [NUM_BYTES-1:0][BYTE_IDX_W-1:0]   top_idx
);
    logic [BYTE_IDX_W-1:0] span;

    assign span = lane_span(mode);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam logic [BYTE_IDX_W-1:0] IDX = BYTE_IDX_W'(i);
        assign cut[i]     = ((IDX & span) == '0);
        assign is_top[i]  = ((IDX & span) == span);
        assign top_idx[i] = IDX | span;
    end
endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice
    import simd_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output logic [BYTE_W-1:0] sum,
    output logic              cout,
    output logic              ovf_cand,
    output logic              a_sign
);
    logic [BYTE_W-1:0] b_eff;
    logic [BYTE_W:0]   wide;

    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, cin};
    assign sum   = wide[BYTE_W-1:0];
    assign cout  = wide[BYTE_W];
    assign a_sign = a[BYTE_W-1];
    // Meaningful only where this byte is the top of its lane.
    assign ovf_cand = (a[BYTE_W-1] == b_eff[BYTE_W-1]) && (sum[BYTE_W-1] != a[BYTE_W-1]);
endmodule

// File: rtl/simd_sat_sel.sv
module simd_sat_sel
    import simd_pkg::*;
(
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0]       raw,
    input  logic [NUM_BYTES-1:0]                   ovf_cand,
    input  logic [NUM_BYTES-1:0]                   a_sign,
    input  logic [NUM_BYTES-1:0]                   is_top,
    input  logic [NUM_BYTES-1:0][BYTE_IDX_W-1:0]   top_idx,
    input  logic                                   sat_en,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0]       data,
    output logic [NUM_BYTES-1:0]                   flags
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
        logic              lane_ovf;
        logic              lane_neg;
        logic [BYTE_W-1:0] clamp;

        assign lane_ovf = ovf_cand[top_idx[i]];
        // On overflow the true result has the sign of the first operand.
        assign lane_neg = a_sign[top_idx[i]];

        always_comb begin
            if (is_top[i])
                clamp = lane_neg ? {1'b1, {(BYTE_W-1){1'b0}}} : {1'b0, {(BYTE_W-1){1'b1}}};
            else
                clamp = lane_neg ? '0 : '1;
        end

        assign flags[i] = lane_ovf;
        assign data[i]  = (sat_en && lane_ovf) ? clamp : raw[i];
    end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
    import simd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           lane_mode,
    input  logic                 op_sub,
    input  logic                 sat_en,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic [NUM_BYTES-1:0] ovf_flags
);
    lane_mode_e mode;
    assign mode = lane_mode_e'(lane_mode);

    logic [NUM_BYTES-1:0]                 cut, is_top;
    logic [NUM_BYTES-1:0][BYTE_IDX_W-1:0] top_idx;
    logic [NUM_BYTES-1:0][BYTE_W-1:0]     raw, sel_data;
    logic [NUM_BYTES-1:0]                 cout, cin, ovf_cand, a_sign, flags_c;

    simd_lane_cut u_cut (
        .mode    (mode),
        .cut     (cut),
        .is_top  (is_top),
        .top_idx (top_idx)
    );

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign cin[i] = op_sub;
        end else begin : g_rest
            assign cin[i] = cut[i] ? op_sub : cout[i-1];
        end

        simd_byte_slice u_slice (
            .a        (opa[i*BYTE_W +: BYTE_W]),
            .b        (opb[i*BYTE_W +: BYTE_W]),
            .sub      (op_sub),
            .cin      (cin[i]),
            .sum      (raw[i]),
            .cout     (cout[i]),
            .ovf_cand (ovf_cand[i]),
            .a_sign   (a_sign[i])
        );
    end

    simd_sat_sel u_sel (
        .raw      (raw),
        .ovf_cand (ovf_cand),
        .a_sign   (a_sign),
        .is_top   (is_top),
        .top_idx  (top_idx),
        .sat_en   (sat_en),
        .data     (sel_data),
        .flags    (flags_c)
    );

    lane_pkt_t  pkt_q;
    lane_mode_e mode_q;
    logic       sat_q;
    logic       vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q  <= '0;
            mode_q <= LANE_8;
            sat_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                pkt_q.data <= sel_data;
                pkt_q.ovf  <= flags_c;
                mode_q     <= mode;
                sat_q      <= sat_en;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = pkt_q.data;
    assign ovf_flags = pkt_q.ovf;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(ovf_flags)));

    // R10
    wide_flag_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == LANE_64) |-> (ovf_flags == '0 || ovf_flags == '1));

    // R10
    half_flag_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == LANE_32) |->
            ($countones(ovf_flags[3:0]) % 4 == 0 && $countones(ovf_flags[7:4]) % 4 == 0));

    // R7
    // R8
    clamp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_q && mode_q == LANE_64 && ovf_flags[NUM_BYTES-1]) |->
            (result == {1'b0, {(DATA_W-1){1'b1}}} || result == {1'b1, {(DATA_W-1){1'b0}}}));

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && result == '0 && ovf_flags == '0));
endmodule

// File: tb/sim_simd_sat_addsub.sv
module sim_simd_sat_addsub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  lane_mode = 2'b00;
    logic        op_sub = 1'b0;
    logic        sat_en = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int checks = 0;
    int errors = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sat_addsub u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
        .op_sub(op_sub), .sat_en(sat_en), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .ovf_flags(ovf_flags)
    );

    function automatic logic [63:0] next_rng(logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Reference model per the requirements, arithmetic on sign-extended lanes.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                         input logic sub, input logic sat,
                         output logic [63:0] exp_r, output logic [7:0] exp_f);
        int lw, nl;
        exp_r = '0;
        exp_f = '0;
        lw = 8 << m;
        nl = 64 / lw;
        for (int l = 0; l < nl; l++) begin
            logic signed [65:0] x, y, t, mx, mn, r;
            logic ov;
            x = '0; y = '0;
            for (int j = 0; j < 66; j++) begin
                x[j] = (j < lw) ? a[l*lw+j] : a[l*lw+lw-1];
                y[j] = (j < lw) ? b[l*lw+j] : b[l*lw+lw-1];
            end
            t  = sub ? (x - y) : (x + y);
            mx = (66'sd1 <<< (lw-1)) - 66'sd1;
            mn = -(66'sd1 <<< (lw-1));
            ov = (t > mx) || (t < mn);
            r  = (sat && ov) ? ((t > mx) ? mx : mn) : t;
            for (int j = 0; j < lw; j++) exp_r[l*lw+j] = r[j];
            for (int k = 0; k < lw/8; k++) exp_f[l*(lw/8)+k] = ov;
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                          input logic sub, input logic sat, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, m, sub, sat, er, ef);
        @(negedge clk);
        opa = a; opb = b; lane_mode = m; op_sub = sub; sat_en = sat; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (!out_valid || result !== er || ovf_flags !== ef) begin
            errors++;
            $display("FAIL %s mode=%0d sub=%0b sat=%0b a=%h b=%h: got v=%0b r=%h f=%h, want v=1 r=%h f=%h",
                     tag, m, sub, sat, a, b, out_valid, result, ovf_flags, er, ef);
        end
    endtask

    function automatic string tag_for(logic [1:0] m, logic sub, logic sat);
        if (sat) return sub ? "R6/R8 sub-sat" : "R5/R7 add-sat";
        return sub ? "R4/R9 sub-wrap" : "R3/R9 add-wrap";
    endfunction

    function automatic logic [63:0] splat(logic [1:0] m, logic signed [65:0] v);
        logic [63:0] o;
        int lw;
        lw = 8 << m;
        for (int j = 0; j < 64; j++) o[j] = v[j % lw];
        return o;
    endfunction

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] held_r;
        logic [7:0]  held_f;
        logic signed [65:0] cv [7];

        repeat (3) @(negedge clk);
        // R13 reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || ovf_flags !== '0) begin
            errors++;
            $display("FAIL R13 reset: got v=%0b r=%h f=%h, want 0 0 0", out_valid, result, ovf_flags);
        end
        rst = 1'b0;
        @(negedge clk);

        // Near-exhaustive 8-bit sweep, distinct value per byte (R1, R2, R10)
        for (int c = 0; c < 4; c++) begin
            for (int ai = 0; ai < 256; ai += 7) begin
                for (int bi = 0; bi < 256; bi++) begin
                    logic [63:0] a, b;
                    for (int k = 0; k < 8; k++) begin
                        a[k*8 +: 8] = 8'(ai + k*37);
                        b[k*8 +: 8] = 8'(bi) ^ 8'(k*29);
                    end
                    run_op(a, b, 2'b00, c[0], c[1], tag_for(2'b00, c[0], c[1]));
                end
            end
        end

        // Signed extremes per wider lane width (R7, R8, R5, R6)
        for (int m = 1; m < 4; m++) begin
            int lw;
            lw = 8 << m;
            cv[0] = 0; cv[1] = 1; cv[2] = -1;
            cv[3] = (66'sd1 <<< (lw-1)) - 1; cv[4] = -(66'sd1 <<< (lw-1));
            cv[5] = cv[3] - 1; cv[6] = cv[4] + 1;
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 7; i++)
                    for (int j = 0; j < 7; j++)
                        run_op(splat(2'(m), cv[i]), splat(2'(m), cv[j]), 2'(m), c[0], c[1],
                               tag_for(2'(m), c[0], c[1]));
        end

        // Pseudo-random vectors in all modes (R1, R3, R4, R10)
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int n = 0; n < 300; n++) begin
                    logic [63:0] a;
                    rng = next_rng(rng); a = rng;
                    rng = next_rng(rng);
                    run_op(a, rng, 2'(m), c[0], c[1], "R1/R10 random");
                end

        // R2 carry isolation at each width
        for (int m = 0; m < 4; m++) begin
            run_op('1, splat(2'(m), 66'sd1), 2'(m), 1'b0, 1'b0, "R2 add isolation");
            run_op('0, splat(2'(m), 66'sd1), 2'(m), 1'b1, 1'b0, "R2 sub isolation");
        end

        // R11 pulse width and R12 hold
        held_r = result;
        held_f = ovf_flags;
        opa = 64'h7F7F_7F7F_7F7F_7F7F; opb = 64'h0101_0101_0101_0101;
        lane_mode = 2'b00; sat_en = 1'b1; op_sub = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 pulse: got v=%0b want 0", out_valid);
        end
        checks++;
        if (result !== held_r || ovf_flags !== held_f) begin
            errors++;
            $display("FAIL R12 hold: got r=%h f=%h want r=%h f=%h", result, ovf_flags, held_r, held_f);
        end
        // back-to-back strobes keep valid high for each
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || result !== 64'h7F7F_7F7F_7F7F_7F7F) begin
            errors++;
            $display("FAIL R7/R11 first strobe: got v=%0b r=%h want 1 7f7f7f7f7f7f7f7f", out_valid, result);
        end
        opb = 64'h0;
        @(negedge clk); in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || result !== 64'h7F7F_7F7F_7F7F_7F7F || ovf_flags !== 8'h00) begin
            errors++;
            $display("FAIL R11 second strobe: got v=%0b r=%h f=%h want 1 7f7f7f7f7f7f7f7f 00",
                     out_valid, result, ovf_flags);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 drop: got v=%0b want 0", out_valid);
        end

        // R13 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || ovf_flags !== '0) begin
            errors++;
            $display("FAIL R13 re-reset: got v=%0b r=%h f=%h want 0 0 0", out_valid, result, ovf_flags);
        end
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule